// File: doc/BRIEF.md
# Synchronous FIFO with Hysteretic Almost-Full Flag

This block is a single-clock first-in first-out buffer for a stream of data words. Words enter through a valid/ready write port and leave through a valid/ready read port. The read side is show-ahead: while the buffer holds anything, the oldest word is already on `rd_data`. The block also reports how many words it holds at any moment.

An almost-full flag is meant for throttling the upstream source. It turns on when the occupancy reaches a programmable high-water mark. It turns off only when the occupancy falls to a separate, lower low-water mark. While the occupancy lies between the two marks, the flag keeps its previous value, so a source that hovers near one level does not see the flag toggle. If the low-water mark is programmed at or above the high-water mark, the flag simply reflects whether the occupancy has reached the high-water mark.

Back-pressure rules:
- A write beat transfers on a rising clock edge when `wr_valid` and `wr_ready` are both high.
- A read beat transfers when `rd_valid` and `rd_ready` are both high.
- A source must hold its word while `wr_ready` is low. Presenting `wr_valid` into a full buffer is treated as an overflow event. The word is dropped and a sticky status bit is set.
- Raising `rd_ready` while the buffer is empty is treated as an underflow event. Nothing is popped and a second sticky bit is set.
- Both sticky bits clear only on reset.

All flags are gathered into one status word.

Top module: `hyst_fifo`

## Requirements
- R1: `wr_ready` is high exactly when the stored count is below DEPTH. A beat with `wr_valid` and `wr_ready` high stores `wr_data` at the tail, and words leave in the order they were written.
- R2: `rd_valid` is high exactly when the stored count is nonzero. `rd_data` shows the oldest stored word, and a beat with `rd_valid` and `rd_ready` high removes it.
- R3: `level` equals the number of stored words after every edge. A cycle that moves both a write beat and a read beat leaves `level` unchanged.
- R4: `almost_full` is high in every cycle where `level` is greater than or equal to `afull_on_thr`.
- R5: `almost_full` is low in every cycle where `level` is below `afull_on_thr` and at or below `afull_off_thr`.
- R6: When `level` lies strictly between `afull_off_thr` and `afull_on_thr`, `almost_full` holds the value it had in the previous cycle.
- R7: When `afull_off_thr` is greater than or equal to `afull_on_thr`, `almost_full` equals (`level` >= `afull_on_thr`) in every cycle.
- R8: `wr_valid` high while `wr_ready` is low stores nothing and sets the overflow bit, `status[3]`, from the next cycle.
- R9: `rd_ready` high while `rd_valid` is low removes nothing and sets the underflow bit, `status[4]`, from the next cycle.
- R10: The status word holds empty in bit 0, full in bit 1 and `almost_full` in bit 2. After reset, `level` is 0 and `status` is 5'b00001 whenever `afull_on_thr` is nonzero.
- R11: Once set, the overflow and underflow bits stay high until reset, and reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Buffer can accept a word |
| wr_data | input | DATA_W | Word to write |
| rd_valid | output | 1 | Oldest word is available |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | DATA_W | Oldest stored word |
| afull_on_thr | input | CNT_W | High-water mark for the almost-full flag |
| afull_off_thr | input | CNT_W | Low-water mark for the almost-full flag |
| level | output | CNT_W | Number of stored words |
| almost_full | output | 1 | Hysteretic almost-full flag |
| status | output | 5 | {underflow, overflow, almost_full, full, empty} |

## Verification
The bound checker watches, on every cycle, the following properties:
- the count's bounds and its step after each combination of write and read beats;
- the tie between the handshake outputs and the count;
- the three bands of the almost-full flag;
- the setting and stickiness of the error bits.

Word ordering through the buffer, the exact content of `rd_data`, the reset value of the status word and the clearing of the sticky bits by a later reset can only be shown by the bench. It shows them with a behavioural queue model compared every cycle, across these scenarios:
- fill and drain;
- pushing into a full buffer and popping an empty one;
- steady simultaneous traffic;
- mixed random traffic under both normal and inverted thresholds.

// File: rtl/hf_pkg.sv
package hf_pkg;
  // Status word layout: bit 0 empty, bit 1 full, bit 2 almost-full,
  // bit 3 overflow (sticky), bit 4 underflow (sticky).
  typedef struct packed {
    logic underflow;
    logic overflow;
    logic almost_full;
    logic full;
    logic empty;
  } fifo_status_t;

  localparam int unsigned ERR_OVF = 0;
  localparam int unsigned ERR_UDF = 1;
  localparam int unsigned N_ERR   = 2;
endpackage

// File: rtl/hf_storage.sv
module hf_storage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
    end
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/hf_occupancy.sv
module hf_occupancy #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      unique case ({push, pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign count = count_q;
  assign full  = (count_q == CAP);
  assign empty = (count_q == '0);
endmodule

// File: rtl/hf_hyst_flag.sv
module hf_hyst_flag #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] on_thr,
  input  logic [CNT_W-1:0] off_thr,
  output logic             flag
);
  logic held_q;
  logic reach_on, reach_off;

  assign reach_on  = (count >= on_thr);
  assign reach_off = (count <= off_thr);

  // The high-water test wins, so inverted marks reduce to it alone.
  always_comb begin
    if (reach_on)       flag = 1'b1;
    else if (reach_off) flag = 1'b0;
    else                flag = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= flag;
  end
endmodule

// File: rtl/hf_sticky.sv
module hf_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/hyst_fifo.sv
module hyst_fifo
  import hf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  afull_on_thr,
  input  logic [CNT_W-1:0]  afull_off_thr,
  output logic [CNT_W-1:0]  level,
  output logic              almost_full,
  output logic [4:0]        status
);
  logic             full, empty, push, pop;
  logic [N_ERR-1:0] err_set, err_q;
  fifo_status_t     st;

  assign push = wr_valid && !full;
  assign pop  = rd_ready && !empty;

  assign err_set[ERR_OVF] = wr_valid && full;
  assign err_set[ERR_UDF] = rd_ready && empty;

  hf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  hf_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .count(level), .full(full), .empty(empty)
  );

  hf_hyst_flag #(.CNT_W(CNT_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .count(level),
    .on_thr(afull_on_thr), .off_thr(afull_off_thr), .flag(almost_full)
  );

  hf_sticky #(.N(N_ERR)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .q(err_q)
  );

  assign wr_ready = !full;
  assign rd_valid = !empty;

  always_comb begin
    st.empty       = empty;
    st.full        = full;
    st.almost_full = almost_full;
    st.overflow    = err_q[ERR_OVF];
    st.underflow   = err_q[ERR_UDF];
  end
  assign status = st;
endmodule

// File: rtl/hyst_fifo_chk.sv
module hyst_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [CNT_W-1:0] afull_on_thr,
  input logic [CNT_W-1:0] afull_off_thr,
  input logic [CNT_W-1:0] level,
  input logic             almost_full,
  input logic [4:0]       status
);
  logic wbeat, rbeat;
  assign wbeat = wr_valid && wr_ready;
  assign rbeat = rd_valid && rd_ready;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R3
  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wbeat && !rbeat) |=> level == $past(level) + CNT_W'(1)); // R3
  AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rbeat && !wbeat) |=> level == $past(level) - CNT_W'(1)); // R3
  AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wbeat == rbeat) |=> level == $past(level)); // R3
  AST_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == (level != CNT_W'(DEPTH))); // R1
  AST_VALID_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (level != '0)); // R2
  AST_AFULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= afull_on_thr) |-> almost_full); // R4
  AST_AFULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (level < afull_on_thr && level <= afull_off_thr) |-> !almost_full); // R5
  AST_AFULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (level < afull_on_thr && level > afull_off_thr) |-> almost_full == $past(almost_full)); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> status[3]); // R8
  AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |=> status[4]); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |=> status[3]); // R11
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |=> status[4]); // R11
endmodule

bind hyst_fifo hyst_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .afull_on_thr(afull_on_thr),
  .afull_off_thr(afull_off_thr), .level(level), .almost_full(almost_full),
  .status(status)
);

// File: tb/tb_hyst_fifo.sv
`timescale 1ns/1ps
module tb_hyst_fifo;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CNT_W-1:0]  on_thr = CNT_W'(12), off_thr = CNT_W'(4);
  logic wr_ready, rd_valid, almost_full;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  level;
  logic [4:0]        status;

  always #2 clk = ~clk;

  hyst_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .afull_on_thr(on_thr), .afull_off_thr(off_thr),
    .level(level), .almost_full(almost_full), .status(status)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DATA_W-1:0] q[$];
  bit m_held = 0, m_ovf = 0, m_udf = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit wv, input logic [DATA_W-1:0] wd, input bit rr);
    int lvl;
    bit e_af, e_push, e_pop;
    string tag;
    wr_valid = wv; wr_data = wd; rd_ready = rr;
    #1;
    lvl = q.size();
    if (lvl >= int'(on_thr))       e_af = 1'b1;
    else if (lvl <= int'(off_thr)) e_af = 1'b0;
    else                           e_af = m_held;
    if (off_thr >= on_thr)         tag = "R7 almost_full inverted marks";
    else if (lvl >= int'(on_thr))  tag = "R4 almost_full high band";
    else if (lvl <= int'(off_thr)) tag = "R5 almost_full low band";
    else                           tag = "R6 almost_full hold band";
    chk(wr_ready == (lvl < DEPTH), "R1 wr_ready", wr_ready, lvl < DEPTH);
    chk(rd_valid == (lvl > 0), "R2 rd_valid", rd_valid, lvl > 0);
    if (lvl > 0) chk(rd_data == q[0], "R1/R2 order rd_data", rd_data, q[0]);
    chk(int'(level) == lvl, "R3 level", level, lvl);
    chk(almost_full == e_af, tag, almost_full, e_af);
    chk(status[3] == m_ovf, "R8 overflow bit", status[3], m_ovf);
    chk(status[4] == m_udf, "R9 underflow bit", status[4], m_udf);
    chk(status[2:0] == {e_af, lvl == DEPTH, lvl == 0}, "R10 status low bits",
        status[2:0], {e_af, lvl == DEPTH, lvl == 0});
    e_push = wv && (lvl < DEPTH);
    e_pop  = rr && (lvl > 0);
    @(posedge clk);
    if (e_pop) void'(q.pop_front());
    if (e_push) q.push_back(wd);
    if (wv && lvl == DEPTH) m_ovf = 1;
    if (rr && lvl == 0) m_udf = 1;
    m_held = e_af;
    @(negedge clk);
  endtask

  task automatic do_reset();
    wr_valid = 0; rd_ready = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    q.delete(); m_held = 0; m_ovf = 0; m_udf = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(level == '0, "R10 reset level", level, 0);
    chk(status == 5'b00001, "R10/R11 reset status", status, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R4 R6: fill past both marks to full
    for (int i = 0; i < DEPTH; i++) step(1, DATA_W'(16'h100 + i), 0);
    // R8: offer into full buffer
    step(1, 16'hDEAD, 0);
    step(1, 16'hBEEF, 0);
    // R2 R5 R6: drain, then R9 read from empty
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1);
    step(0, '0, 1);
    step(0, '0, 1);
    // R3: steady simultaneous traffic at mid level
    for (int i = 0; i < 6; i++) step(1, DATA_W'(16'h200 + i), 0);
    for (int i = 0; i < 20; i++) step(1, DATA_W'(16'h300 + i), 1);
    // R6: hover between marks
    for (int i = 0; i < 200; i++) step($urandom_range(0, 1) == 1, DATA_W'($urandom), $urandom_range(0, 1) == 1);
    // R11: clearing only by reset
    do_reset();
    // R7: inverted marks, random traffic
    on_thr = CNT_W'(5); off_thr = CNT_W'(10);
    for (int i = 0; i < 400; i++) step($urandom_range(0, 2) != 0, DATA_W'($urandom), $urandom_range(0, 2) == 0);
    for (int i = 0; i < 400; i++) step($urandom_range(0, 2) == 0, DATA_W'($urandom), $urandom_range(0, 2) != 0);
    // normal marks again with threshold changes while traffic flows
    on_thr = CNT_W'(10); off_thr = CNT_W'(3);
    for (int i = 0; i < 600; i++) begin
      if (i % 150 == 75) begin
        on_thr = CNT_W'($urandom_range(1, DEPTH));
        off_thr = CNT_W'($urandom_range(0, DEPTH));
      end
      step($urandom_range(0, 3) < (i % 300 < 150 ? 3 : 1), DATA_W'($urandom),
           $urandom_range(0, 3) < (i % 300 < 150 ? 1 : 3));
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule